// File: doc/BRIEF.md
# AUX Channel Host Register Front-End

This block is the host-facing half of a display AUX channel controller. An AXI4-Lite slave port gives software a small register window. Through that window software loads the target address and up to sixteen bytes of outgoing payload, then writes a command word that launches one request toward a line-side engine. The line-side engine does the serial encoding and bus turnaround. It is outside this block and is reached through a plain valid/ready request port, a byte-pop port for the payload, and a response port. On the response port it streams reply bytes and then signals completion together with a reply code.

The block buffers the reply bytes for software to read one at a time. It records the latest reply code, counts completed reply transactions and counts the data bytes actually received. It runs no retry logic: whatever the reply code, a finished request stays finished until software issues a new command. The block also divides the host clock by an integer to make a one-microsecond tick. The tick is exported for the line-side engine's bit timing, and it also advances a free-running microsecond counter that software can read.

Top module: `aux_host_regs`

## Requirements
- R1: Every AXI4-Lite write and read completes with response code 0 (OKAY), with one transaction in flight on each channel. After reset the divider register (offset 0x10C) reads DIV_RESET (default 100), and the status, reply-count, received-byte and reply-data registers read 0. The address register (0x108, bits [19:0]) and the divider register read back what was written.
- R2: When the block is idle, a write to offset 0x100 starts a request. The command word carries the request code in bits [15:12] and the length minus one in bits [3:0]. From the next cycle req_valid_o is high, with req_cmd_o equal to the code, req_len_o equal to the length (1 to 16) and req_addr_o equal to the address register. req_valid_o stays high until req_ready_i is seen.
- R3: Byte writes to offset 0x104 (bits [7:0]) fill a 16-entry payload FIFO. A write to the full FIFO is dropped. The line side sees the oldest byte on tx_data_o, sees tx_avail_o high while the FIFO is non-empty, and removes a byte with tx_pop_i.
- R4: With divider value N, tick_o pulses for one cycle every N host cycles. N = 0 or N = 1 makes tick_o high on every cycle.
- R5: The register at offset 0x154 starts at 0 after reset and advances by exactly one on every cycle in which tick_o is high.
- R6: Reply bytes received while a request is busy go into a 16-entry reply FIFO, and bytes past sixteen are dropped. Each read of offset 0x134 returns the oldest byte and removes it. A read of the empty FIFO returns 0. Starting a new request empties the reply FIFO.
- R7: Offset 0x138 holds the code that came with the most recent completion (0 = ACK, 1 = NACK, 2 = DEFER).
- R8: Offset 0x13C counts completions. Any write to it clears it to 0.
- R9: Offset 0x148 counts the reply bytes received during the current request, including bytes the reply FIFO dropped and regardless of the programmed length. It restarts at 0 when a request starts.
- R10: Bit 0 of offset 0x14C is high from the start of a request until its completion. A command write while this bit is high changes neither the command register nor the request.
- R11: After a completion with any code, including NACK and DEFER, req_valid_o stays low until software writes a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_awaddr_i | input | ADDR_W | Write address |
| s_awvalid_i | input | 1 | Write address valid |
| s_awready_o | output | 1 | Write address ready |
| s_wdata_i | input | DATA_W | Write data |
| s_wvalid_i | input | 1 | Write data valid |
| s_wready_o | output | 1 | Write data ready |
| s_bresp_o | output | 2 | Write response |
| s_bvalid_o | output | 1 | Write response valid |
| s_bready_i | input | 1 | Write response ready |
| s_araddr_i | input | ADDR_W | Read address |
| s_arvalid_i | input | 1 | Read address valid |
| s_arready_o | output | 1 | Read address ready |
| s_rdata_o | output | DATA_W | Read data |
| s_rresp_o | output | 2 | Read response |
| s_rvalid_o | output | 1 | Read data valid |
| s_rready_i | input | 1 | Read data ready |
| req_valid_o | output | 1 | Request pending toward the line side |
| req_ready_i | input | 1 | Line side accepts the request |
| req_cmd_o | output | 4 | Request code |
| req_addr_o | output | AUX_ADDR_W | Request target address |
| req_len_o | output | LEN_W | Request length in bytes |
| tx_data_o | output | 8 | Oldest payload byte |
| tx_avail_o | output | 1 | Payload FIFO not empty |
| tx_pop_i | input | 1 | Remove the oldest payload byte |
| rsp_byte_valid_i | input | 1 | Reply byte strobe |
| rsp_byte_i | input | 8 | Reply byte |
| rsp_done_i | input | 1 | Reply transaction complete |
| rsp_code_i | input | 4 | Reply code with completion |
| tick_o | output | 1 | One-microsecond tick pulse |

## Verification
The bench fills the payload FIFO beyond sixteen bytes and drains it. A design that wraps instead of dropping would hand back overwritten bytes, or report data left after sixteen pops. It sends eighteen reply bytes against a sixteen-byte request, which separates the true received-byte count from the programmed length and from the FIFO occupancy, then reads past the end of the reply FIFO to expect zero. It completes requests with DEFER and NACK codes and watches for a relaunch. It issues a command while busy and expects the first command to be kept. It measures the tick spacing for dividers 4, 1 and 0, where an off-by-one comparator shows up as a wrong pulse count, and it compares the microsecond register against the ticks it has counted itself.

// File: rtl/aux_host_pkg.sv
package aux_host_pkg;
  localparam logic [11:0] OFF_CMD   = 12'h100;
  localparam logic [11:0] OFF_WDATA = 12'h104;
  localparam logic [11:0] OFF_ADDR  = 12'h108;
  localparam logic [11:0] OFF_DIV   = 12'h10C;
  localparam logic [11:0] OFF_RDATA = 12'h134;
  localparam logic [11:0] OFF_RCODE = 12'h138;
  localparam logic [11:0] OFF_RCNT  = 12'h13C;
  localparam logic [11:0] OFF_RXB   = 12'h148;
  localparam logic [11:0] OFF_STAT  = 12'h14C;
  localparam logic [11:0] OFF_US    = 12'h154;

  localparam logic [1:0] RESP_OKAY = 2'b00;

  typedef enum logic [3:0] {
    CODE_ACK   = 4'd0,
    CODE_NACK  = 4'd1,
    CODE_DEFER = 4'd2
  } reply_code_e;
endpackage

// File: rtl/aux_byte_fifo.sv
module aux_byte_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic do_push, do_pop;

  assign full_o  = (count_q == CNT_W'(DEPTH));
  assign empty_o = (count_q == '0);
  assign do_push = push_i && !full_o;   // full: drop
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= wr_ptr_q + PTR_W'(1);
      if (do_pop)  rd_ptr_q <= rd_ptr_q + PTR_W'(1);
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + CNT_W'(1);
        2'b01:   count_q <= count_q - CNT_W'(1);
        default: ;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !flush_i) |=> (full_o && count_q == $past(count_q))); // R3
  AST_EMPTY_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i && !flush_i) |=> empty_o); // R6
  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o); // R6
endmodule

// File: rtl/aux_tick_gen.sv
module aux_tick_gen #(
  parameter int DIV_W = 8,
  parameter int US_W  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o,
  output logic [US_W-1:0]  us_o
);
  logic [DIV_W-1:0] cnt_q, lim;
  logic [US_W-1:0]  us_q;

  // 0 and 1 both mean "every cycle"
  assign lim    = (div_i <= DIV_W'(1)) ? '0 : div_i - DIV_W'(1);
  assign tick_o = (cnt_q >= lim);
  assign us_o   = us_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      us_q  <= '0;
    end else begin
      cnt_q <= tick_o ? '0 : cnt_q + DIV_W'(1);
      if (tick_o) us_q <= us_q + US_W'(1);
    end
  end

  AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (!tick_o || div_i <= DIV_W'(1))); // R4
  AST_US_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (us_o == $past(us_o) + US_W'(1))); // R5
  AST_US_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |=> $stable(us_o)); // R5
endmodule

// File: rtl/aux_host_regs.sv
module aux_host_regs
  import aux_host_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 16,
  parameter int DIV_W      = 8,
  parameter int DIV_RESET  = 100,
  parameter int US_W       = 32,
  parameter int RXCNT_W    = 8,
  parameter int RCNT_W     = 16,
  parameter int AUX_ADDR_W = 20,
  localparam int LENF_W    = $clog2(FIFO_DEPTH),
  localparam int LEN_W     = LENF_W + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     s_awaddr_i,
  input  logic                  s_awvalid_i,
  output logic                  s_awready_o,
  input  logic [DATA_W-1:0]     s_wdata_i,
  input  logic                  s_wvalid_i,
  output logic                  s_wready_o,
  output logic [1:0]            s_bresp_o,
  output logic                  s_bvalid_o,
  input  logic                  s_bready_i,
  input  logic [ADDR_W-1:0]     s_araddr_i,
  input  logic                  s_arvalid_i,
  output logic                  s_arready_o,
  output logic [DATA_W-1:0]     s_rdata_o,
  output logic [1:0]            s_rresp_o,
  output logic                  s_rvalid_o,
  input  logic                  s_rready_i,
  output logic                  req_valid_o,
  input  logic                  req_ready_i,
  output logic [3:0]            req_cmd_o,
  output logic [AUX_ADDR_W-1:0] req_addr_o,
  output logic [LEN_W-1:0]      req_len_o,
  output logic [7:0]            tx_data_o,
  output logic                  tx_avail_o,
  input  logic                  tx_pop_i,
  input  logic                  rsp_byte_valid_i,
  input  logic [7:0]            rsp_byte_i,
  input  logic                  rsp_done_i,
  input  logic [3:0]            rsp_code_i,
  output logic                  tick_o
);
  localparam int CODE_LSB = 12;

  // host bus
  logic              bvalid_q, rvalid_q;
  logic [DATA_W-1:0] rdata_q, rd_mux;
  logic              wr_en, rd_hs;
  logic [11:0]       waddr, raddr;

  // registers
  logic [3:0]            cmd_code_q;
  logic [LENF_W-1:0]     cmd_lenm1_q;
  logic [AUX_ADDR_W-1:0] aux_addr_q;
  logic [DIV_W-1:0]      div_q;
  logic [3:0]            rcode_q;
  logic [RCNT_W-1:0]     rcnt_q;
  logic [RXCNT_W-1:0]    rxb_q;
  logic                  busy_q, launched_q;
  logic                  wr_cmd, cmd_start;

  // fifos / timebase
  logic       tx_full, tx_empty;
  logic       rx_full, rx_empty, rx_pop;
  logic [7:0] rx_head;
  logic [US_W-1:0] us_cnt;

  assign waddr = 12'(s_awaddr_i);
  assign raddr = 12'(s_araddr_i);

  assign wr_en       = s_awvalid_i && s_wvalid_i && !bvalid_q;
  assign s_awready_o = wr_en;
  assign s_wready_o  = wr_en;
  assign s_bvalid_o  = bvalid_q;
  assign s_bresp_o   = RESP_OKAY;

  assign s_arready_o = !rvalid_q;
  assign rd_hs       = s_arvalid_i && !rvalid_q;
  assign s_rvalid_o  = rvalid_q;
  assign s_rdata_o   = rdata_q;
  assign s_rresp_o   = RESP_OKAY;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bvalid_q <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (wr_en)                      bvalid_q <= 1'b1;
      else if (s_bready_i)            bvalid_q <= 1'b0;
      if (rd_hs) begin
        rvalid_q <= 1'b1;
        rdata_q  <= rd_mux;
      end else if (s_rready_i) begin
        rvalid_q <= 1'b0;
      end
    end
  end

  assign wr_cmd    = wr_en && (waddr == OFF_CMD);
  assign cmd_start = wr_cmd && !busy_q;   // ignored while busy

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_code_q  <= '0;
      cmd_lenm1_q <= '0;
      aux_addr_q  <= '0;
      div_q       <= DIV_W'(DIV_RESET);
    end else begin
      if (cmd_start) begin
        cmd_code_q  <= s_wdata_i[CODE_LSB +: 4];
        cmd_lenm1_q <= s_wdata_i[LENF_W-1:0];
      end
      if (wr_en && waddr == OFF_ADDR) aux_addr_q <= s_wdata_i[AUX_ADDR_W-1:0];
      if (wr_en && waddr == OFF_DIV)  div_q      <= s_wdata_i[DIV_W-1:0];
    end
  end

  // request sequencing: no retry after completion
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      launched_q <= 1'b0;
    end else begin
      if (cmd_start) begin
        busy_q     <= 1'b1;
        launched_q <= 1'b0;
      end else if (rsp_done_i) begin
        busy_q     <= 1'b0;
        launched_q <= 1'b0;
      end else if (req_valid_o && req_ready_i) begin
        launched_q <= 1'b1;
      end
    end
  end

  assign req_valid_o = busy_q && !launched_q;
  assign req_cmd_o   = cmd_code_q;
  assign req_addr_o  = aux_addr_q;
  assign req_len_o   = LEN_W'(cmd_lenm1_q) + LEN_W'(1);

  // reply bookkeeping
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rcode_q <= '0;
      rcnt_q  <= '0;
      rxb_q   <= '0;
    end else begin
      if (rsp_done_i) rcode_q <= rsp_code_i;
      if (wr_en && waddr == OFF_RCNT) rcnt_q <= '0;
      else if (rsp_done_i)            rcnt_q <= rcnt_q + RCNT_W'(1);
      if (cmd_start) rxb_q <= '0;
      else if (rsp_byte_valid_i && busy_q && rxb_q != '1) rxb_q <= rxb_q + RXCNT_W'(1);
    end
  end

  aux_byte_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (1'b0),
    .push_i  (wr_en && waddr == OFF_WDATA),
    .data_i  (s_wdata_i[7:0]),
    .pop_i   (tx_pop_i),
    .data_o  (tx_data_o),
    .full_o  (tx_full),
    .empty_o (tx_empty)
  );
  assign tx_avail_o = !tx_empty;

  assign rx_pop = rd_hs && (raddr == OFF_RDATA);

  aux_byte_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (cmd_start),
    .push_i  (rsp_byte_valid_i && busy_q),
    .data_i  (rsp_byte_i),
    .pop_i   (rx_pop),
    .data_o  (rx_head),
    .full_o  (rx_full),
    .empty_o (rx_empty)
  );

  aux_tick_gen #(.DIV_W(DIV_W), .US_W(US_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (div_q),
    .tick_o (tick_o),
    .us_o   (us_cnt)
  );

  always_comb begin
    rd_mux = '0;
    unique case (raddr)
      OFF_CMD: begin
        rd_mux[CODE_LSB +: 4]  = cmd_code_q;
        rd_mux[LENF_W-1:0]     = cmd_lenm1_q;
      end
      OFF_ADDR:  rd_mux = DATA_W'(aux_addr_q);
      OFF_DIV:   rd_mux = DATA_W'(div_q);
      OFF_RDATA: rd_mux = rx_empty ? '0 : DATA_W'(rx_head);
      OFF_RCODE: rd_mux = DATA_W'(rcode_q);
      OFF_RCNT:  rd_mux = DATA_W'(rcnt_q);
      OFF_RXB:   rd_mux = DATA_W'(rxb_q);
      OFF_STAT:  rd_mux = DATA_W'(busy_q);
      OFF_US:    rd_mux = DATA_W'(us_cnt);
      default:   rd_mux = '0;
    endcase
  end

  AST_NO_RETRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_i |=> !req_valid_o); // R11
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i && !rsp_done_i) |=> req_valid_o); // R2
  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && wr_cmd) |=> ($stable(cmd_code_q) && $stable(cmd_lenm1_q))); // R10
  AST_RCNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && waddr == OFF_RCNT) |=> (rcnt_q == '0)); // R8
  AST_RX_KEEP_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full && !rx_pop && !cmd_start) |=> rx_full); // R6
  AST_TX_KEEP_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_full && !tx_pop_i) |=> tx_full); // R3
endmodule

// File: tb/aux_host_regs_tb_top.sv
module aux_host_regs_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [11:0] awaddr = '0, araddr = '0;
  logic        awvalid = 1'b0, wvalid = 1'b0, arvalid = 1'b0;
  logic [31:0] wdata = '0;
  logic        awready, wready, bvalid, arready, rvalid;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;
  logic        req_valid, req_ready = 1'b0;
  logic [3:0]  req_cmd;
  logic [19:0] req_addr;
  logic [4:0]  req_len;
  logic [7:0]  tx_data;
  logic        tx_avail, tx_pop = 1'b0;
  logic        rsp_bv = 1'b0, rsp_done = 1'b0;
  logic [7:0]  rsp_byte = '0;
  logic [3:0]  rsp_code = '0;
  logic        tick;

  aux_host_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .s_awaddr_i(awaddr), .s_awvalid_i(awvalid), .s_awready_o(awready),
    .s_wdata_i(wdata), .s_wvalid_i(wvalid), .s_wready_o(wready),
    .s_bresp_o(bresp), .s_bvalid_o(bvalid), .s_bready_i(1'b1),
    .s_araddr_i(araddr), .s_arvalid_i(arvalid), .s_arready_o(arready),
    .s_rdata_o(rdata), .s_rresp_o(rresp), .s_rvalid_o(rvalid), .s_rready_i(1'b1),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_cmd_o(req_cmd),
    .req_addr_o(req_addr), .req_len_o(req_len),
    .tx_data_o(tx_data), .tx_avail_o(tx_avail), .tx_pop_i(tx_pop),
    .rsp_byte_valid_i(rsp_bv), .rsp_byte_i(rsp_byte), .rsp_done_i(rsp_done),
    .rsp_code_i(rsp_code), .tick_o(tick)
  );

  int n_chk = 0;
  int n_fail = 0;
  int tick_total = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: read data against queued expectations
  always @(negedge clk) begin
    if (rst_n && tick) tick_total++;
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1 unexpected read data", rdata, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rdata === e && rresp == 2'b00, t, rdata, e);
      end
    end
  end

  task automatic axi_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    while (bvalid) @(negedge clk);
    awaddr = a; wdata = d; awvalid = 1'b1; wvalid = 1'b1;
    @(negedge clk);
    awvalid = 1'b0; wvalid = 1'b0;
    chk(bvalid && bresp == 2'b00, "R1 write response", {30'b0, bresp}, 32'h0);
  endtask

  task automatic axi_rd(input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    while (!arready) @(negedge clk);
    araddr = a; arvalid = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    arvalid = 1'b0;
  endtask

  task automatic axi_rd_us(input string t);
    logic [31:0] e;
    @(negedge clk);
    while (!arready) @(negedge clk);
    #1;
    e = 32'(tick_total - (tick ? 1 : 0));
    araddr = 12'h154; arvalid = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    arvalid = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); rsp_bv = 1'b1; rsp_byte = b;
    @(negedge clk); rsp_bv = 1'b0;
  endtask

  task automatic send_done(input logic [3:0] c);
    @(negedge clk); rsp_done = 1'b1; rsp_code = c;
    @(negedge clk); rsp_done = 1'b0;
  endtask

  task automatic pop_tx;
    @(negedge clk); tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
  endtask

  task automatic count_ticks(input int win, output int n);
    n = 0;
    do @(negedge clk); while (!tick);
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (tick) n++;
    end
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    finish_run();
  end

  initial begin
    int n;
    bit stayed_low;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // reset state R1
    chk(req_valid == 1'b0, "R1 reset req_valid", {31'b0, req_valid}, 32'h0);
    axi_rd(12'h10C, 32'd100, "R1 reset divider");
    axi_rd(12'h14C, 32'h0, "R1 reset status");
    axi_rd(12'h13C, 32'h0, "R1 reset reply count");
    axi_rd(12'h148, 32'h0, "R1 reset byte count");
    axi_rd(12'h134, 32'h0, "R1 reset reply data");
    axi_rd_us("R5 microsecond counter after reset");

    axi_wr(12'h108, 32'h0001_2345);
    axi_rd(12'h108, 32'h0001_2345, "R1 address readback");

    // first request: 3 payload bytes, DEFER reply
    axi_wr(12'h104, 32'h11);
    axi_wr(12'h104, 32'h22);
    axi_wr(12'h104, 32'h33);
    axi_wr(12'h100, 32'h0000_9002);
    chk(req_valid == 1'b1, "R2 request raised", {31'b0, req_valid}, 32'h1);
    chk(req_cmd == 4'h9, "R2 request code", {28'b0, req_cmd}, 32'h9);
    chk(req_len == 5'd3, "R2 request length", {27'b0, req_len}, 32'h3);
    chk(req_addr == 20'h12345, "R2 request address", {12'b0, req_addr}, 32'h12345);
    axi_rd(12'h14C, 32'h1, "R10 busy set");
    axi_wr(12'h100, 32'h0000_1005);
    axi_rd(12'h100, 32'h0000_9002, "R10 command kept while busy");
    chk(req_valid == 1'b1 && req_len == 5'd3, "R2 request held", {27'b0, req_len}, 32'h3);

    chk(tx_avail && tx_data == 8'h11, "R3 payload byte 0", {24'b0, tx_data}, 32'h11);
    pop_tx();
    chk(tx_data == 8'h22, "R3 payload byte 1", {24'b0, tx_data}, 32'h22);
    pop_tx();
    chk(tx_data == 8'h33, "R3 payload byte 2", {24'b0, tx_data}, 32'h33);
    pop_tx();
    chk(!tx_avail, "R3 payload drained", {31'b0, tx_avail}, 32'h0);

    @(negedge clk); req_ready = 1'b1;
    @(negedge clk); req_ready = 1'b0;
    chk(req_valid == 1'b0, "R2 request accepted", {31'b0, req_valid}, 32'h0);

    send_byte(8'hA1);
    send_byte(8'hA2);
    send_done(4'd2);
    stayed_low = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (req_valid) stayed_low = 1'b0;
    end
    chk(stayed_low, "R11 no retry after DEFER", {31'b0, !stayed_low}, 32'h0);
    axi_rd(12'h14C, 32'h0, "R10 busy cleared");
    axi_rd(12'h138, 32'h2, "R7 reply code DEFER");
    axi_rd(12'h13C, 32'h1, "R8 reply count 1");
    axi_rd(12'h148, 32'h2, "R9 two bytes received");
    axi_rd(12'h134, 32'hA1, "R6 reply byte 0");
    axi_rd(12'h134, 32'hA2, "R6 reply byte 1");
    axi_rd(12'h134, 32'h0, "R6 empty reply reads zero");

    axi_wr(12'h13C, 32'h0);
    axi_rd(12'h13C, 32'h0, "R8 reply count cleared");

    // payload FIFO overflow
    for (int i = 0; i < 18; i++) axi_wr(12'h104, 32'(8'h50 + i));
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      chk(tx_avail && tx_data == 8'(8'h50 + i), "R3 payload order after overflow",
          {24'b0, tx_data}, 32'(8'h50 + i));
      pop_tx();
    end
    chk(!tx_avail, "R3 extra writes dropped", {31'b0, tx_avail}, 32'h0);

    // reply overflow: 18 bytes against length 16, ACK
    axi_wr(12'h100, 32'h0000_400F);
    chk(req_len == 5'd16, "R2 length 16", {27'b0, req_len}, 32'h10);
    for (int i = 0; i < 18; i++) send_byte(8'(8'h60 + i));
    send_done(4'd0);
    axi_rd(12'h148, 32'd18, "R9 byte count beyond length");
    axi_rd(12'h138, 32'h0, "R7 reply code ACK");
    axi_rd(12'h13C, 32'h1, "R8 count after clear");
    for (int i = 0; i < 16; i++) axi_rd(12'h134, 32'(8'h60 + i), "R6 reply order");
    axi_rd(12'h134, 32'h0, "R6 bytes past 16 dropped");

    // NACK with no data; new command flushes reply state
    send_byte(8'hEE);                // idle: must be ignored
    axi_wr(12'h100, 32'h0000_1000);
    axi_rd(12'h148, 32'h0, "R9 byte count restarts");
    axi_rd(12'h134, 32'h0, "R6 reply FIFO flushed at start");
    send_done(4'd1);
    @(negedge clk);
    chk(req_valid == 1'b0, "R11 no retry after NACK", {31'b0, req_valid}, 32'h0);
    axi_rd(12'h138, 32'h1, "R7 reply code NACK");
    axi_rd(12'h13C, 32'h2, "R8 reply count 2");

    // timebase
    axi_wr(12'h10C, 32'd4);
    axi_rd(12'h10C, 32'd4, "R1 divider readback");
    count_ticks(40, n);
    chk(n == 10, "R4 divider 4 spacing", 32'(n), 32'd10);
    axi_rd_us("R5 microsecond counter div 4");
    axi_wr(12'h10C, 32'd1);
    count_ticks(40, n);
    chk(n == 40, "R4 divider 1 every cycle", 32'(n), 32'd40);
    axi_wr(12'h10C, 32'd0);
    count_ticks(40, n);
    chk(n == 40, "R4 divider 0 every cycle", 32'(n), 32'd40);
    axi_rd_us("R5 microsecond counter div 0");
    axi_wr(12'h10C, 32'd7);
    count_ticks(70, n);
    chk(n == 10, "R4 divider 7 spacing", 32'(n), 32'd10);
    axi_rd_us("R5 microsecond counter div 7");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R1 all reads answered", 32'(exp_q.size()), 32'h0);
    finish_run();
  end
endmodule